// File: doc/BRIEF.md
# Shared PCI Bus Arbiter with a Non-Preemptible Legacy Requester

This block decides which agent owns a shared PCI bus segment. The contenders are the host (which requests on behalf of the processors), a parameterized set of ordinary bus masters (seven by default), and one dedicated southbridge requester. The southbridge runs legacy ISA DMA traffic. All request and grant lines are active low. At most one grant is driven at a time.

The host and the ordinary masters share one round-robin ring. A member of that ring that holds the grant loses it as soon as any other agent requests. The southbridge is treated differently. Once it is granted, it keeps the bus for as long as it holds its request, whoever else is waiting, so a long DMA sequence cannot deadlock. When a grant is withdrawn, the arbiter waits until the current transaction has ended before it issues the next grant. The transaction has ended when frame_n and irdy_n are both sampled high. When nobody is asking for the bus, the grant parks on the host.

Top module: `pci_legacy_arbiter`

## Requirements
- R1: At most one of host_gnt_n, gnt_n[i] and sb_gnt_n is low in any cycle. A low gnt_n[i] means that ordinary master i owns the bus.
- R2: While rst_n is low and in the first cycle after it, host_gnt_n is low and every other grant is high.
- R3: When ownership moves from one agent to another, at least one clock with all grants high comes between the two grants.
- R4: If the host or an ordinary master holds the grant and, at a clock edge, any other agent's request is sampled low (including sb_req_n), then all grants are high after that edge.
- R5: While sb_gnt_n is low and sb_req_n stays low, sb_gnt_n stays low, whatever the other request lines do.
- R6: When sb_req_n is sampled high while the southbridge holds the grant, all grants are high after that edge.
- R7: While all grants are high, no new grant is issued at an edge where frame_n or irdy_n is low. The next grant appears at the first edge where both are sampled high.
- R8: At the edge where a new grant is issued, a low sb_req_n wins over every request from the ring.
- R9: Otherwise the new grant goes to the first requester found in ring order after the agent that was granted last. Ring order is host, master 0, master 1 … master N-1, and it wraps back to the host.
- R10: If no request is pending when a grant is issued, the host is granted (parking). A master that drops its own request while nobody else is asking loses its grant, and the bus then parks on the host.
- R11: An owner from the ring keeps its grant while no other request is pending, as long as it either keeps requesting or is the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_n | input | 1 | Host request, active low |
| req_n | input | N_MST | Ordinary master requests, active low |
| sb_req_n | input | 1 | Southbridge request, active low |
| frame_n | input | 1 | Bus FRAME# as seen on the segment |
| irdy_n | input | 1 | Bus IRDY# as seen on the segment |
| host_gnt_n | output | 1 | Host grant, active low |
| gnt_n | output | N_MST | Ordinary master grants, active low |
| sb_gnt_n | output | 1 | Southbridge grant, active low |

## Verification
The hardest case to reach is a southbridge that keeps the bus while ring agents are asking for it. The test also has to show that, after the southbridge releases, the ring resumes from the right place. The stimulus parks the bus on the host and raises a southbridge request together with a master request, so the arbiter must choose between them. It then holds the southbridge request for several cycles with the other request still pending and frame_n driven busy. Only after that is the southbridge request released, so the waiting master's grant can be checked against the ring position. A separate phase makes the host and two masters request at once, so that the pointer has to wrap from the top master back to the host.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      ST_OWN   = 1'b0,
      ST_DRAIN = 1'b1
   } arb_st_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int NR = 8,
   parameter int IW = 3
) (
   input  logic [NR-1:0] req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] win
);
   logic [IW:0] pos;

   always_comb begin
      any = 1'b0;
      win = last;
      pos = '0;
      for (int k = 1; k <= NR; k++) begin
         pos = {1'b0, last} + (IW+1)'(k);
         if (pos >= (IW+1)'(NR)) pos = pos - (IW+1)'(NR);
         if (!any && req[pos[IW-1:0]]) begin
            any = 1'b1;
            win = pos[IW-1:0];
         end
      end
   end
endmodule

// File: rtl/arb_gnt_decode.sv
module arb_gnt_decode #(
   parameter int NR = 8,
   parameter int IW = 3
) (
   input  logic          en_ring,
   input  logic [IW-1:0] idx,
   input  logic          en_sb,
   output logic [NR-1:0] ring_gnt_n,
   output logic          sb_gnt_n
);
   for (genvar i = 0; i < NR; i++) begin : g_line
      assign ring_gnt_n[i] = ~(en_ring && (idx == IW'(i)));
   end
   assign sb_gnt_n = ~en_sb;
endmodule

// File: rtl/pci_legacy_arbiter.sv
module pci_legacy_arbiter
   import arb_pkg::*;
#(
   parameter int N_MST = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_req_n,
   input  logic [N_MST-1:0] req_n,
   input  logic             sb_req_n,
   input  logic             frame_n,
   input  logic             irdy_n,
   output logic             host_gnt_n,
   output logic [N_MST-1:0] gnt_n,
   output logic             sb_gnt_n
);
   localparam int NR = N_MST + 1;
   localparam int IW = (NR > 2) ? $clog2(NR) : 1;

   if (N_MST < 1 || N_MST > 15) begin : g_bad_cfg
      $error("pci_legacy_arbiter: N_MST must be 1..15");
   end

   arb_st_e       st_q, st_d;
   logic          own_sb_q, own_sb_d;
   logic [IW-1:0] own_q, own_d;
   logic [IW-1:0] last_q, last_d;

   logic [NR-1:0] ring_req;
   logic          sb_req, bus_idle, others, any_ring;
   logic [IW-1:0] pick;
   logic [NR-1:0] ring_gnt_n;

   assign ring_req = ~{req_n, host_req_n};
   assign sb_req   = ~sb_req_n;
   assign bus_idle = frame_n & irdy_n;
   assign others   = (|(ring_req & ~(NR'(1) << own_q))) | sb_req;

   arb_rr_pick #(.NR(NR), .IW(IW)) i_pick (
      .req  (ring_req),
      .last (last_q),
      .any  (any_ring),
      .win  (pick)
   );

   always_comb begin
      st_d     = st_q;
      own_sb_d = own_sb_q;
      own_d    = own_q;
      last_d   = last_q;
      if (st_q == ST_OWN) begin
         if (own_sb_q) begin
            if (!sb_req) st_d = ST_DRAIN;
         end else if (others) begin
            st_d = ST_DRAIN;
         end else if (!ring_req[own_q] && own_q != '0) begin
            st_d = ST_DRAIN;
         end
      end else if (bus_idle) begin
         st_d = ST_OWN;
         if (sb_req) begin
            own_sb_d = 1'b1;
         end else begin
            own_sb_d = 1'b0;
            own_d    = any_ring ? pick : '0;
            last_d   = any_ring ? pick : '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_OWN;
         own_sb_q <= 1'b0;
         own_q    <= '0;
         last_q   <= '0;
      end else begin
         st_q     <= st_d;
         own_sb_q <= own_sb_d;
         own_q    <= own_d;
         last_q   <= last_d;
      end
   end

   arb_gnt_decode #(.NR(NR), .IW(IW)) i_dec (
      .en_ring    (st_q == ST_OWN && !own_sb_q),
      .idx        (own_q),
      .en_sb      (st_q == ST_OWN && own_sb_q),
      .ring_gnt_n (ring_gnt_n),
      .sb_gnt_n   (sb_gnt_n)
   );

   assign host_gnt_n = ring_gnt_n[0];
   assign gnt_n      = ring_gnt_n[NR-1:1];

   logic [NR-1:0] g_ring;
   logic [NR:0]   g_all;
   assign g_ring = ~{gnt_n, host_gnt_n};
   assign g_all  = {~sb_gnt_n, g_ring};

   // R1
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(g_all));

   // R3
   handover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_all != '0 && g_all != $past(g_all)) |-> $past(g_all) == '0);

   // R4
   ring_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_ring != '0 && ((ring_req & ~g_ring) != '0 || !sb_req_n)) |=> g_all == '0);

   // R5
   sb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sb_gnt_n && !sb_req_n) |=> !sb_gnt_n);

   // R7
   drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_all == '0 && !(frame_n && irdy_n)) |=> g_all == '0);

   // R8
   sb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_all == '0 && frame_n && irdy_n && !sb_req_n) |=> !sb_gnt_n);

   // R10
   park_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_all == '0 && frame_n && irdy_n && ring_req == '0 && sb_req_n) |=> !host_gnt_n);
endmodule

// File: tb/test_pci_legacy_arbiter.sv
module test_pci_legacy_arbiter;
   localparam int N = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_req_n = 1'b1;
   logic [N-1:0] req_n = '1;
   logic sb_req_n = 1'b1;
   logic frame_n = 1'b1;
   logic irdy_n = 1'b1;
   logic host_gnt_n;
   logic [N-1:0] gnt_n;
   logic sb_gnt_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   typedef struct {
      logic [N+1:0] exp;
      string        tag;
   } item_t;
   item_t q[$];

   always #5 clk = ~clk;

   pci_legacy_arbiter #(.N_MST(N)) i_pci_legacy_arbiter (
      .clk(clk), .rst_n(rst_n), .host_req_n(host_req_n), .req_n(req_n),
      .sb_req_n(sb_req_n), .frame_n(frame_n), .irdy_n(irdy_n),
      .host_gnt_n(host_gnt_n), .gnt_n(gnt_n), .sb_gnt_n(sb_gnt_n)
   );

   // who: -1 none, 0 host, 1..N master who-1, N+1 southbridge
   function automatic logic [N+1:0] gv(int who);
      logic [N+1:0] v = '1;
      if (who >= 0) v[who] = 1'b0;
      return v;
   endfunction

   function automatic logic [N+1:0] act();
      return {sb_gnt_n, gnt_n, host_gnt_n};
   endfunction

   task automatic check(logic [N+1:0] got, logic [N+1:0] exp, string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: grants got %b expected %b", tag, got, exp);
      end
   endtask

   // driver: inputs already set at this negedge; expect result after next posedge
   task automatic tick(int who, string tag);
      item_t it;
      it.exp = gv(who);
      it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check(act(), it.exp, it.tag);
         n_chk++;
         if ($countones(~act()) > 1) begin
            n_fail++;
            $display("FAIL R1: grants got %b expected at most one low", act());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(act(), gv(0), "R2 in reset");
      rst_n = 1'b1;
      tick(0, "R2 after reset");
      tick(0, "R10 parked idle");

      // master 2 asks while host parked
      req_n[2] = 1'b0;
      tick(-1, "R4 host preempted");
      tick(3, "R9 first after host");
      tick(3, "R11 keeps grant");
      tick(3, "R11 keeps grant");

      // masters 5 and 0 ask, bus busy
      req_n[2] = 1'b1; req_n[5] = 1'b0; req_n[0] = 1'b0; frame_n = 1'b0;
      tick(-1, "R4 m2 preempted");
      tick(-1, "R7 frame busy");
      tick(-1, "R7 frame busy");
      frame_n = 1'b1; irdy_n = 1'b0;
      tick(-1, "R7 irdy busy");
      irdy_n = 1'b1;
      tick(6, "R9 after m2 picks m5");
      tick(-1, "R4 m5 preempted by m0");
      tick(1, "R9 wrap to m0");
      req_n = '1;
      tick(-1, "R10 owner dropped");
      tick(0, "R10 park host");

      // southbridge and master 3 at once
      sb_req_n = 1'b0; req_n[3] = 1'b0;
      tick(-1, "R4 host preempted by sb");
      tick(N+1, "R8 sb wins");
      frame_n = 1'b0;
      tick(N+1, "R5 sb kept");
      req_n[6] = 1'b0;
      tick(N+1, "R5 sb kept");
      tick(N+1, "R5 sb kept");
      req_n[6] = 1'b1; frame_n = 1'b1; sb_req_n = 1'b1;
      tick(-1, "R6 sb released");
      tick(4, "R9 m3 after host");
      req_n[3] = 1'b1;
      tick(-1, "R10 m3 dropped");
      tick(0, "R10 park host");

      // southbridge preempts an ordinary master
      req_n[1] = 1'b0;
      tick(-1, "R3 gap");
      tick(2, "R9 m1");
      sb_req_n = 1'b0;
      tick(-1, "R4 m1 preempted by sb");
      tick(N+1, "R8 sb");
      sb_req_n = 1'b1;
      tick(-1, "R6 sb released");
      tick(2, "R9 m1 again");

      // host, m1, m6 all asking
      host_req_n = 1'b0; req_n[6] = 1'b0;
      tick(-1, "R4 m1 preempted");
      tick(7, "R9 m6 next");
      tick(-1, "R3 gap");
      tick(0, "R9 wrap to host");
      tick(-1, "R3 gap");
      tick(2, "R9 m1 after host");
      host_req_n = 1'b1; req_n = '1;
      tick(-1, "R10 all dropped");
      tick(0, "R10 park host");
      host_req_n = 1'b0;
      tick(0, "R11 host keeps");
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule